// File: doc/BRIEF.md
# Indexed Effective-Address Unit with Register Auto-Update

This block turns already-decoded indexed-mode fields into a 16-bit effective address. It also produces the matching write-back for the pointer register. The base is one of four pointer registers, the program counter, or nothing at all (absolute pointer form). The offset is one of three kinds: no offset, a sign-extended constant of 5, 8 or 16 bits, or an accumulator. The pointer registers can step automatically in two ways. Post-increment addresses with the old value and then adds 1 or 2. Pre-decrement subtracts 1 or 2 first and addresses with the result.

When the indirect flag is set, the computed address points at a big-endian 16-bit pointer. The unit reads that pointer one byte at a time over a simple read port and reports it as the final address. The read port is combinational: `mem_rdata` must reflect `mem_addr` in the same cycle. A field combination that has no meaning ends with `done` and `err` together. In that case nothing is written back and memory is not touched. All arithmetic wraps modulo 2^16.

Top module: `idx_addr_unit`

## Requirements
- R1: After reset, `done`, `err`, `wb_en`, `mem_req` and `busy` are all low.
- R2: For constant offsets (`off_kind` 1 = 5-bit, 2 = 8-bit, 3 = 16-bit), only the low 5, 8 or 16 bits of `const_off` are used. That value is sign-extended and added to the base.
- R3: For accumulator offsets, `off_kind` 4 adds sign-extended `acc_a` and 5 adds sign-extended `acc_b`. Code 6 adds the 16-bit value {`acc_a`,`acc_b`}. Code 0 adds nothing.
- R4: `base_sel` 0..3 selects `reg_x`, `reg_y`, `reg_u`, `reg_s`, and 4 selects `reg_pc`. The PC base is legal only with `off_kind` 2 or 3 and `upd_kind` 0.
- R5: `upd_kind` 1 and 2 (post-increment by 1 or 2) address with the old register value. The write-back is old+1 or old+2.
- R6: `upd_kind` 3 and 4 (pre-decrement by 1 or 2) use old-1 or old-2 both as the address and as the write-back value.
- R7: A direct access raises `done` in the cycle after `start` is taken. An indirect access instead reads byte p with `mem_req` in the cycle after `start`, then byte p+1 in the next cycle. It raises `done` one cycle later with `ea` = {byte p, byte p+1}.
- R8: `base_sel` 5 (absolute) requires `off_kind` 3, `upd_kind` 0 and `indirect` = 1. In that form `const_off` is the pointer location.
- R9: These combinations are illegal: an auto-update with any offset, an indirect access with a step of 1, a PC or absolute base outside its allowed forms, and an unused encoding. Each raises `done` and `err` one cycle after `start`, with `wb_en` low and no `mem_req`.
- R10: Address, write-back and pointer-byte address arithmetic wrap modulo 2^16.
- R11: `start` is ignored while `busy` is high.
- R12: `wb_en` pulses with `done` only for a legal auto-update. `wb_sel` then holds `base_sel[1:0]`, and `wb_val` holds the updated register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address computation |
| base_sel | input | 3 | Base: 0 X, 1 Y, 2 U, 3 S, 4 PC, 5 absolute |
| off_kind | input | 3 | Offset: 0 none, 1 c5, 2 c8, 3 c16, 4 A, 5 B, 6 D |
| upd_kind | input | 3 | Update: 0 none, 1 +1, 2 +2, 3 -1, 4 -2 |
| indirect | input | 1 | Fetch 16-bit pointer at the computed address |
| const_off | input | 16 | Constant offset or absolute pointer location |
| reg_x | input | 16 | Pointer register X |
| reg_y | input | 16 | Pointer register Y |
| reg_u | input | 16 | Pointer register U |
| reg_s | input | 16 | Pointer register S |
| reg_pc | input | 16 | Program counter value used as base |
| acc_a | input | 8 | Accumulator A (high half of D) |
| acc_b | input | 8 | Accumulator B (low half of D) |
| mem_rdata | input | 8 | Byte read at `mem_addr` |
| mem_req | output | 1 | Pointer byte read request |
| mem_addr | output | 16 | Pointer byte address |
| busy | output | 1 | Indirect fetch in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal combination (with `done`) |
| ea | output | 16 | Effective address, valid with `done` |
| wb_en | output | 1 | Register write-back strobe |
| wb_sel | output | 2 | Register to write back |
| wb_val | output | 16 | Updated register value |

## Verification
A wrong base or offset selection, or a stale pointer byte, shows up as a wrong `ea` in the very cycle `done` rises. That is one cycle after `start` for direct forms and three cycles after for indirect forms. A corrupted state register shows up one cycle earlier. It appears as a missing or misaddressed `mem_req`, or as `done` arriving at the wrong edge. The bench compares these per cycle, so such a fault is caught on the edge where it first appears. A write-back that uses the wrong sign or the wrong ordering is visible at once. The step appears either on `ea` (pre-decrement) or only on `wb_val` (post-increment).

// File: rtl/idx_pkg.sv
package idx_pkg;
    localparam int DW = 16;
    localparam int BW = 8;

    typedef enum logic [2:0] {
        BASE_X = 3'd0, BASE_Y = 3'd1, BASE_U = 3'd2, BASE_S = 3'd3,
        BASE_PC = 3'd4, BASE_ABS = 3'd5
    } base_e;

    typedef enum logic [2:0] {
        OFF_NONE = 3'd0, OFF_C5 = 3'd1, OFF_C8 = 3'd2, OFF_C16 = 3'd3,
        OFF_ACCA = 3'd4, OFF_ACCB = 3'd5, OFF_ACCD = 3'd6
    } off_e;

    typedef enum logic [2:0] {
        UPD_NONE = 3'd0, UPD_INC1 = 3'd1, UPD_INC2 = 3'd2,
        UPD_DEC1 = 3'd3, UPD_DEC2 = 3'd4
    } upd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0, ST_RDHI = 2'd1, ST_RDLO = 2'd2
    } state_e;

    typedef struct packed {
        state_e          st;
        logic [BW-1:0]   hi;
        logic            pend_wb;
        logic            mem_req;
        logic [DW-1:0]   mem_addr;
        logic            done;
        logic            err;
        logic [DW-1:0]   ea;
        logic            wb_en;
        logic [1:0]      wb_sel;
        logic [DW-1:0]   wb_val;
    } unit_state_t;
endpackage

// File: rtl/idx_mode_check.sv
module idx_mode_check
    import idx_pkg::*;
(
    input  logic [2:0] base_sel,
    input  logic [2:0] off_kind,
    input  logic [2:0] upd_kind,
    input  logic       indirect,
    output logic       legal
);
    base_e b;
    off_e  o;
    upd_e  u;
    logic  step_one;

    always_comb begin
        b = base_e'(base_sel);
        o = off_e'(off_kind);
        u = upd_e'(upd_kind);
        step_one = (u == UPD_INC1) || (u == UPD_DEC1);
        legal = 1'b0;
        if (base_sel <= 3'd3) begin
            if (upd_kind > 3'd4) begin
                legal = 1'b0;
            end else if (u != UPD_NONE) begin
                legal = (o == OFF_NONE) && !(indirect && step_one);
            end else begin
                legal = (off_kind <= 3'd6);
            end
        end else if (b == BASE_PC) begin
            legal = (u == UPD_NONE) && ((o == OFF_C8) || (o == OFF_C16));
        end else if (b == BASE_ABS) begin
            legal = (u == UPD_NONE) && (o == OFF_C16) && indirect;
        end
    end
endmodule

// File: rtl/idx_offset_gen.sv
module idx_offset_gen
    import idx_pkg::*;
#(
    parameter int W    = DW,
    parameter int AW   = BW,
    parameter int SHRT = 5
) (
    input  logic [2:0]   off_kind,
    input  logic [W-1:0] const_off,
    input  logic [AW-1:0] acc_a,
    input  logic [AW-1:0] acc_b,
    output logic [W-1:0] off_val
);
    localparam int EXT_S = W - SHRT;
    localparam int EXT_A = W - AW;

    logic [W-1:0] c_short, c_byte, a_ext, b_ext;

    always_comb begin
        c_short = {{EXT_S{const_off[SHRT-1]}}, const_off[SHRT-1:0]};
        c_byte  = {{EXT_A{const_off[AW-1]}},   const_off[AW-1:0]};
        a_ext   = {{EXT_A{acc_a[AW-1]}}, acc_a};
        b_ext   = {{EXT_A{acc_b[AW-1]}}, acc_b};
        case (off_e'(off_kind))
            OFF_C5:   off_val = c_short;
            OFF_C8:   off_val = c_byte;
            OFF_C16:  off_val = const_off;
            OFF_ACCA: off_val = a_ext;
            OFF_ACCB: off_val = b_ext;
            OFF_ACCD: off_val = {acc_a, acc_b};
            default:  off_val = '0;
        endcase
    end
endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
    import idx_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [2:0]   base_sel,
    input  logic [2:0]   upd_kind,
    input  logic [W-1:0] reg_x,
    input  logic [W-1:0] reg_y,
    input  logic [W-1:0] reg_u,
    input  logic [W-1:0] reg_s,
    input  logic [W-1:0] reg_pc,
    input  logic [W-1:0] off_val,
    output logic [W-1:0] ptr,
    output logic [W-1:0] upd_val,
    output logic         upd_on
);
    logic [W-1:0] base_v;
    logic [W-1:0] step;
    logic [W-1:0] stepped_up, stepped_dn;

    always_comb begin
        case (base_e'(base_sel))
            BASE_X:  base_v = reg_x;
            BASE_Y:  base_v = reg_y;
            BASE_U:  base_v = reg_u;
            BASE_S:  base_v = reg_s;
            BASE_PC: base_v = reg_pc;
            default: base_v = '0;
        endcase

        case (upd_e'(upd_kind))
            UPD_INC1, UPD_DEC1: step = W'(1);
            UPD_INC2, UPD_DEC2: step = W'(2);
            default:            step = '0;
        endcase

        stepped_up = base_v + step;
        stepped_dn = base_v - step;

        case (upd_e'(upd_kind))
            UPD_INC1, UPD_INC2: begin
                ptr     = base_v;
                upd_val = stepped_up;
                upd_on  = 1'b1;
            end
            UPD_DEC1, UPD_DEC2: begin
                ptr     = stepped_dn;
                upd_val = stepped_dn;
                upd_on  = 1'b1;
            end
            default: begin
                ptr     = base_v + off_val;
                upd_val = base_v;
                upd_on  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/idx_addr_unit.sv
module idx_addr_unit
    import idx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [2:0]  base_sel,
    input  logic [2:0]  off_kind,
    input  logic [2:0]  upd_kind,
    input  logic        indirect,
    input  logic [15:0] const_off,
    input  logic [15:0] reg_x,
    input  logic [15:0] reg_y,
    input  logic [15:0] reg_u,
    input  logic [15:0] reg_s,
    input  logic [15:0] reg_pc,
    input  logic [7:0]  acc_a,
    input  logic [7:0]  acc_b,
    input  logic [7:0]  mem_rdata,
    output logic        mem_req,
    output logic [15:0] mem_addr,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [15:0] ea,
    output logic        wb_en,
    output logic [1:0]  wb_sel,
    output logic [15:0] wb_val
);
    logic          legal;
    logic [DW-1:0] off_val;
    logic [DW-1:0] ptr;
    logic [DW-1:0] upd_val;
    logic          upd_on;

    unit_state_t q, d;

    idx_mode_check chk_i (
        .base_sel (base_sel),
        .off_kind (off_kind),
        .upd_kind (upd_kind),
        .indirect (indirect),
        .legal    (legal)
    );

    idx_offset_gen #(.W(DW), .AW(BW), .SHRT(5)) off_i (
        .off_kind  (off_kind),
        .const_off (const_off),
        .acc_a     (acc_a),
        .acc_b     (acc_b),
        .off_val   (off_val)
    );

    idx_ea_calc #(.W(DW)) ea_i (
        .base_sel (base_sel),
        .upd_kind (upd_kind),
        .reg_x    (reg_x),
        .reg_y    (reg_y),
        .reg_u    (reg_u),
        .reg_s    (reg_s),
        .reg_pc   (reg_pc),
        .off_val  (off_val),
        .ptr      (ptr),
        .upd_val  (upd_val),
        .upd_on   (upd_on)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.err     = 1'b0;
        d.wb_en   = 1'b0;
        d.mem_req = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (!legal) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else if (indirect) begin
                        d.st       = ST_RDHI;
                        d.mem_req  = 1'b1;
                        d.mem_addr = ptr;
                        d.pend_wb  = upd_on;
                        d.wb_sel   = base_sel[1:0];
                        d.wb_val   = upd_val;
                    end else begin
                        d.done    = 1'b1;
                        d.ea      = ptr;
                        d.wb_en   = upd_on;
                        d.pend_wb = 1'b0;
                        d.wb_sel  = base_sel[1:0];
                        d.wb_val  = upd_val;
                    end
                end
            end
            ST_RDHI: begin
                d.hi       = mem_rdata;
                d.mem_req  = 1'b1;
                d.mem_addr = q.mem_addr + DW'(1);
                d.st       = ST_RDLO;
            end
            ST_RDLO: begin
                d.ea      = {q.hi, mem_rdata};
                d.done    = 1'b1;
                d.wb_en   = q.pend_wb;
                d.pend_wb = 1'b0;
                d.st      = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_req  = q.mem_req;
    assign mem_addr = q.mem_addr;
    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign err      = q.err;
    assign ea       = q.ea;
    assign wb_en    = q.wb_en;
    assign wb_sel   = q.wb_sel;
    assign wb_val   = q.wb_val;

    // R9
    err_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !wb_en && !mem_req));

    // R12
    wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (done && !err));

    // R7
    lo_byte_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + 16'd1));

    // R7
    fetch_ends_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_req) |-> done);

    // R11
    busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !done);

    // R1
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !busy) |-> !mem_req);
endmodule

// File: tb/idx_addr_unit_tb_top.sv
`timescale 1ns/1ps
module idx_addr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  base_sel = '0, off_kind = '0, upd_kind = '0;
    logic        indirect = 1'b0;
    logic [15:0] const_off = '0;
    logic [15:0] reg_x = 16'h1000, reg_y = 16'h2000, reg_u = 16'h3000;
    logic [15:0] reg_s = 16'h4000, reg_pc = 16'h8000;
    logic [7:0]  acc_a = '0, acc_b = '0;
    logic [7:0]  mem_rdata;
    logic        mem_req, busy, done, err, wb_en;
    logic [15:0] mem_addr, ea, wb_val;
    logic [1:0]  wb_sel;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    assign mem_rdata = mem_byte(mem_addr);

    idx_addr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_sel(base_sel),
        .off_kind(off_kind), .upd_kind(upd_kind), .indirect(indirect),
        .const_off(const_off), .reg_x(reg_x), .reg_y(reg_y), .reg_u(reg_u),
        .reg_s(reg_s), .reg_pc(reg_pc), .acc_a(acc_a), .acc_b(acc_b),
        .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .busy(busy), .done(done), .err(err), .ea(ea), .wb_en(wb_en),
        .wb_sel(wb_sel), .wb_val(wb_val)
    );

    task automatic check(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic int sx(input int v, input int bits);
        int m = v & ((1 << bits) - 1);
        if (m >= (1 << (bits - 1))) m -= (1 << bits);
        return m;
    endfunction

    // Behavioural reference: legality, pointer, write-back
    function automatic bit ref_legal(int b, int o, int u, bit ind);
        if (b <= 3) begin
            if (u > 4) return 0;
            if (u != 0) return (o == 0) && !(ind && (u == 1 || u == 3));
            return o <= 6;
        end
        if (b == 4) return (u == 0) && (o == 2 || o == 3);
        if (b == 5) return (u == 0) && (o == 3) && ind;
        return 0;
    endfunction

    task automatic run_op(input string rq, input int b, input int o, input int u,
                          input bit ind, input int k, input bit poke);
        int bv, ov, p, wv, fin, stepn;
        bit lg, wbe;
        case (b)
            0: bv = reg_x; 1: bv = reg_y; 2: bv = reg_u; 3: bv = reg_s;
            4: bv = reg_pc; default: bv = 0;
        endcase
        case (o)
            1: ov = sx(k, 5);
            2: ov = sx(k, 8);
            3: ov = k & 16'hFFFF;
            4: ov = sx(acc_a, 8);
            5: ov = sx(acc_b, 8);
            6: ov = acc_a * 256 + acc_b;
            default: ov = 0;
        endcase
        stepn = (u == 1 || u == 3) ? 1 : 2;
        lg  = ref_legal(b, o, u, ind);
        wbe = lg && (u != 0);
        if (u == 1 || u == 2) begin p = bv; wv = (bv + stepn) & 16'hFFFF; end
        else if (u == 3 || u == 4) begin p = (bv - stepn) & 16'hFFFF; wv = p; end
        else begin p = (bv + ov) & 16'hFFFF; wv = bv; end
        fin = ind ? (mem_byte(16'(p)) * 256 + mem_byte(16'(p + 1))) : p;

        @(negedge clk);
        base_sel = 3'(b); off_kind = 3'(o); upd_kind = 3'(u);
        indirect = ind; const_off = 16'(k); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!lg || !ind) begin
            check(rq, "done", done, 1);
            check(rq, "err", err, !lg);
            check(rq, "mem_req", mem_req, 0);
            check(rq, "wb_en", wb_en, wbe);
            if (lg) check(rq, "ea", ea, fin);
            if (wbe) begin
                check(rq, "wb_sel", wb_sel, b & 3);
                check(rq, "wb_val", wb_val, wv);
            end
        end else begin
            check(rq, "hi req", mem_req, 1);
            check(rq, "hi addr", mem_addr, p);
            check(rq, "early done", done, 0);
            if (poke) begin
                base_sel = 3'd0; off_kind = 3'd0; upd_kind = 3'd2;
                indirect = 1'b0; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            check(rq, "lo req", mem_req, 1);
            check(rq, "lo addr", mem_addr, (p + 1) & 16'hFFFF);
            check(rq, "early done", done, 0);
            @(negedge clk);
            check(rq, "done", done, 1);
            check(rq, "err", err, 0);
            check(rq, "mem_req off", mem_req, 0);
            check(rq, "ea", ea, fin);
            check(rq, "wb_en", wb_en, wbe);
            if (wbe) begin
                check(rq, "wb_sel", wb_sel, b & 3);
                check(rq, "wb_val", wb_val, wv);
            end
        end
        @(negedge clk);
        check(rq, "done cleared", done, 0);
        check(rq, "idle", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "done", done, 0);
        check("R1", "err", err, 0);
        check("R1", "wb_en", wb_en, 0);
        check("R1", "mem_req", mem_req, 0);
        check("R1", "busy", busy, 0);
        rst_n = 1'b1;

        // R2: constant offsets, upper bits of const_off ignored
        run_op("R2", 0, 1, 0, 0, 16'hFF1F, 0);   // -1 from 5 bits
        run_op("R2", 1, 1, 0, 0, 16'h000F, 0);   // +15
        run_op("R2", 2, 2, 0, 0, 16'hAA80, 0);   // -128
        run_op("R2", 3, 3, 0, 0, 16'h1234, 0);
        // R3: accumulator offsets
        acc_a = 8'hF0; acc_b = 8'h7F;
        run_op("R3", 0, 4, 0, 0, 0, 0);
        run_op("R3", 1, 5, 0, 0, 0, 0);
        run_op("R3", 2, 6, 0, 0, 0, 0);
        run_op("R3", 3, 0, 0, 0, 0, 0);
        // R4: PC base legal with 8/16-bit offsets
        run_op("R4", 4, 2, 0, 0, 16'h00FE, 0);
        run_op("R4", 4, 3, 0, 0, 16'h7000, 0);
        run_op("R4", 4, 1, 0, 0, 16'h0003, 0);   // illegal 5-bit with PC
        // R5: post-increment
        run_op("R5", 0, 0, 1, 0, 0, 0);
        run_op("R5", 3, 0, 2, 0, 0, 0);
        // R6: pre-decrement
        run_op("R6", 1, 0, 3, 0, 0, 0);
        run_op("R6", 2, 0, 4, 0, 0, 0);
        // R7: indirect forms
        run_op("R7", 0, 0, 0, 1, 0, 0);
        run_op("R7", 1, 2, 0, 1, 16'h0010, 0);
        run_op("R7", 4, 3, 0, 1, 16'h0100, 0);
        run_op("R7", 2, 0, 2, 1, 0, 0);           // post-inc 2 indirect
        run_op("R12", 3, 0, 4, 1, 0, 0);          // pre-dec 2 indirect
        // R8: absolute pointer location
        run_op("R8", 5, 3, 0, 1, 16'hBEEF, 0);
        run_op("R8", 5, 3, 0, 0, 16'hBEEF, 0);    // illegal: not indirect
        // R9: illegal combinations
        run_op("R9", 0, 0, 1, 1, 0, 0);
        run_op("R9", 1, 0, 3, 1, 0, 0);
        run_op("R9", 2, 2, 2, 0, 16'h0004, 0);
        run_op("R9", 4, 3, 1, 0, 0, 0);
        run_op("R9", 6, 0, 0, 0, 0, 0);
        run_op("R9", 0, 7, 0, 0, 0, 0);
        run_op("R9", 0, 0, 5, 0, 0, 0);
        // R10: wrap-around
        reg_x = 16'hFFFF; reg_y = 16'h0000; reg_u = 16'hFFF0;
        run_op("R10", 0, 0, 2, 0, 0, 0);
        run_op("R10", 1, 0, 4, 0, 0, 0);
        run_op("R10", 2, 3, 0, 0, 16'h0020, 0);
        run_op("R10", 0, 0, 0, 1, 0, 0);          // pointer bytes at FFFF, 0000
        // R11: start while busy ignored
        reg_x = 16'h1234;
        run_op("R11", 1, 2, 0, 1, 16'h0040, 1);
        // R12: write-back only on auto-update
        reg_s = 16'h0101;
        run_op("R12", 3, 0, 1, 0, 0, 0);
        run_op("R12", 3, 2, 0, 0, 16'h0001, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule